// File: doc/BRIEF.md
# Multi-Channel Line Interface System-Side Data Port

This block sits between a framer and the line-side circuitry of a multi-channel T1/E1 line interface. Each channel has a transmit path, which captures positive and negative rail data from the framer on an edge of that channel's transmit clock, and a receive path, which presents recovered rail data to the framer on an edge of that channel's receive clock. A single global control register, written and read over a simple register bus, sets the choices that apply to every channel. These are the rail format (dual or single), the transmit sampling edge, the receive update edge, the data polarity, and automatic substitution of an all-ones pattern on any channel whose loss-of-signal input is raised.

The channel clocks are slow compared with the block clock `clk`. Each lane detects the edges of its channel clocks synchronously, in the `clk` domain. When a lane sees its selected edge on `clk` cycle N, its registered rail outputs change on that same `clk` edge and are visible during cycle N+1.

Each transmit lane holds a three-state machine. The states are `TX_PASS` (framer data is passed through), `TX_MARK_P` (the last forced mark was sent on the positive rail) and `TX_MARK_N` (the last forced mark was sent on the negative rail). At a selected transmit edge, the lane moves or stays as follows:

- Without forcing, every state goes to `TX_PASS`.
- With forcing, `TX_PASS` and `TX_MARK_N` go to `TX_MARK_P`.
- With forcing in dual-rail mode, `TX_MARK_P` goes to `TX_MARK_N`.
- With forcing in single-rail mode, `TX_MARK_P` stays in `TX_MARK_P`.

Between selected edges the state does not change.

Top module: `liu_sysif`

## Requirements
- R1: After reset the control register reads 0x00, every line-side transmit output and every receive rail output is 0, and every transmit lane is in `TX_PASS`.
- R2: A register write stores bits 7..3 and reads them back unchanged. Bits 2..0 ignore writes and always read 0. The field positions are: bit 7 single-rail, bit 6 auto all-ones, bit 5 receive falling edge, bit 4 transmit rising edge, bit 3 active-low polarity.
- R3: With bit 4 at 0, the transmit rails are captured at falling edges of the channel's transmit clock. With bit 4 at 1, they are captured at rising edges. The line-side transmit outputs change one `clk` edge after the edge is observed.
- R4: With bit 5 at 0, the receive rail outputs update at rising edges of the channel's receive clock. With bit 5 at 1, they update at falling edges. Between updates the receive rail outputs hold.
- R5: With bit 3 at 1, both transmit rail inputs are treated as active-low (a mark is a 0 at the pin). Both receive rail outputs also present marks as 0.
- R6: With bit 7 at 1 (single-rail), the negative transmit input is ignored and the line-side negative output becomes 0 at the next sampling edge. The negative receive output is 0 at all times. Polarity still applies to the positive rails.
- R7: With bit 6 at 1, a channel whose loss-of-signal input is 1 at its sampling edge emits a mark instead of the framer data. Other channels pass their data unchanged.
- R8: In dual-rail mode the forced marks alternate between rails, starting on the positive rail when forcing begins. In single-rail mode every forced mark is on the positive rail.
- R9: Forced marks appear on the line as marks (1) whatever the polarity setting.
- R10: The line-side transmit outputs change only at a selected transmit edge. Entering or leaving all-ones substitution therefore never yields a partial bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; channel clock edges are detected on it |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| tclk_i | input | NCH | Per-channel transmit clock |
| tx_pos_i | input | NCH | Per-channel positive transmit rail from the framer |
| tx_neg_i | input | NCH | Per-channel negative transmit rail from the framer |
| rlos_i | input | NCH | Per-channel receive loss-of-signal flag |
| line_tx_pos_o | output | NCH | Per-channel positive transmit rail toward the line (1 = mark) |
| line_tx_neg_o | output | NCH | Per-channel negative transmit rail toward the line (1 = mark) |
| rclk_i | input | NCH | Per-channel receive clock |
| line_rx_pos_i | input | NCH | Per-channel recovered positive rail from the line (1 = mark) |
| line_rx_neg_i | input | NCH | Per-channel recovered negative rail from the line (1 = mark) |
| rx_pos_o | output | NCH | Per-channel positive receive rail to the framer |
| rx_neg_o | output | NCH | Per-channel negative receive rail to the framer |

## Verification
The bench sweeps all 32 control settings on a two-channel build. Under each setting it drives pseudo-random clock toggles, rail data and loss-of-signal changes. A design that captured on the wrong clock edge would show data one half-period early or late, and so would fail the hold checks between edges. The bench also exercises the alternation of forced marks across the rails, including a loss-of-signal input that drops and rises again so that alternation must restart on the positive rail. Further cases are the single-rail masking of the negative rails, and forced marks under active-low polarity, where a design that inverted after substitution would emit spaces. Loss-of-signal and clock edges are independent per channel, so a lane that leaked its state into the other would be caught.

// File: rtl/liu_sysif_pkg.sv
package liu_sysif_pkg;

    localparam int CFG_W  = 8;
    localparam int RSVD_W = 3;
    localparam int FLD_W  = CFG_W - RSVD_W;

    // Field order follows register bits 7..3
    typedef struct packed {
        logic single_rail;
        logic auto_ones;
        logic rx_fall;
        logic tx_rise;
        logic inv_pol;
    } liu_cfg_t;

    typedef enum logic [1:0] {
        TX_PASS   = 2'd0,
        TX_MARK_P = 2'd1,
        TX_MARK_N = 2'd2
    } tx_state_e;

endpackage

// File: rtl/liu_cfg_reg.sv
module liu_cfg_reg
    import liu_sysif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output liu_cfg_t         cfg
);

    logic [FLD_W-1:0] fields_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else if (we) begin
            fields_q <= wdata[CFG_W-1:RSVD_W];
        end
    end

    assign rdata = {fields_q, {RSVD_W{1'b0}}};
    assign cfg   = liu_cfg_t'(fields_q);

    p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata[CFG_W-1:RSVD_W] == $past(wdata[CFG_W-1:RSVD_W]));

endmodule

// File: rtl/liu_tx_lane.sv
module liu_tx_lane
    import liu_sysif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  liu_cfg_t cfg,
    input  logic     tclk_i,
    input  logic     pos_i,
    input  logic     neg_i,
    input  logic     los_i,
    output logic     line_pos_o,
    output logic     line_neg_o
);

    tx_state_e state_q, state_d;
    logic      tclk_q;
    logic      edge_w, force_w;
    logic      data_p, data_n;
    logic      pos_d, neg_d;

    always_ff @(posedge clk) begin
        if (!rst_n) tclk_q <= 1'b0;
        else        tclk_q <= tclk_i;
    end

    assign edge_w  = cfg.tx_rise ? (tclk_i & ~tclk_q) : (~tclk_i & tclk_q);
    assign force_w = cfg.auto_ones & los_i;
    assign data_p  = pos_i ^ cfg.inv_pol;
    assign data_n  = cfg.single_rail ? 1'b0 : (neg_i ^ cfg.inv_pol);

    // Next state and next outputs
    always_comb begin
        state_d = state_q;
        pos_d   = line_pos_o;
        neg_d   = line_neg_o;
        if (edge_w) begin
            if (!force_w) begin
                state_d = TX_PASS;
                pos_d   = data_p;
                neg_d   = data_n;
            end else begin
                unique case (state_q)
                    TX_MARK_P: begin
                        if (cfg.single_rail) begin
                            state_d = TX_MARK_P;
                            pos_d   = 1'b1;
                            neg_d   = 1'b0;
                        end else begin
                            state_d = TX_MARK_N;
                            pos_d   = 1'b0;
                            neg_d   = 1'b1;
                        end
                    end
                    TX_PASS, TX_MARK_N: begin
                        state_d = TX_MARK_P;
                        pos_d   = 1'b1;
                        neg_d   = 1'b0;
                    end
                    default: begin
                        state_d = TX_PASS;
                    end
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_PASS;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pos_o <= 1'b0;
            line_neg_o <= 1'b0;
        end else begin
            line_pos_o <= pos_d;
            line_neg_o <= neg_d;
        end
    end

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_w |=> $stable(line_pos_o) && $stable(line_neg_o));

    p_forced_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w && force_w |=> line_pos_o || line_neg_o);

    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w && force_w && !cfg.single_rail && state_q == TX_MARK_P
        |=> line_neg_o && !line_pos_o);

endmodule

// File: rtl/liu_rx_lane.sv
module liu_rx_lane
    import liu_sysif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  liu_cfg_t cfg,
    input  logic     rclk_i,
    input  logic     line_pos_i,
    input  logic     line_neg_i,
    output logic     rx_pos_o,
    output logic     rx_neg_o
);

    logic rclk_q, edge_w, neg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) rclk_q <= 1'b0;
        else        rclk_q <= rclk_i;
    end

    assign edge_w = cfg.rx_fall ? (~rclk_i & rclk_q) : (rclk_i & ~rclk_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pos_o <= 1'b0;
            neg_q    <= 1'b0;
        end else if (edge_w) begin
            rx_pos_o <= line_pos_i ^ cfg.inv_pol;
            neg_q    <= line_neg_i ^ cfg.inv_pol;
        end
    end

    assign rx_neg_o = neg_q & ~cfg.single_rail;

    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_w |=> $stable(rx_pos_o));

endmodule

// File: rtl/liu_sysif.sv
module liu_sysif
    import liu_sysif_pkg::*;
#(
    parameter int NCH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [NCH-1:0]   tclk_i,
    input  logic [NCH-1:0]   tx_pos_i,
    input  logic [NCH-1:0]   tx_neg_i,
    input  logic [NCH-1:0]   rlos_i,
    output logic [NCH-1:0]   line_tx_pos_o,
    output logic [NCH-1:0]   line_tx_neg_o,
    input  logic [NCH-1:0]   rclk_i,
    input  logic [NCH-1:0]   line_rx_pos_i,
    input  logic [NCH-1:0]   line_rx_neg_i,
    output logic [NCH-1:0]   rx_pos_o,
    output logic [NCH-1:0]   rx_neg_o
);

    liu_cfg_t cfg;

    liu_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        liu_tx_lane u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (cfg),
            .tclk_i     (tclk_i[ch]),
            .pos_i      (tx_pos_i[ch]),
            .neg_i      (tx_neg_i[ch]),
            .los_i      (rlos_i[ch]),
            .line_pos_o (line_tx_pos_o[ch]),
            .line_neg_o (line_tx_neg_o[ch])
        );

        liu_rx_lane u_rx (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (cfg),
            .rclk_i     (rclk_i[ch]),
            .line_pos_i (line_rx_pos_i[ch]),
            .line_neg_i (line_rx_neg_i[ch]),
            .rx_pos_o   (rx_pos_o[ch]),
            .rx_neg_o   (rx_neg_o[ch])
        );
    end

endmodule

// File: tb/tb_liu_sysif.sv
module tb_liu_sysif;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [7:0]     cfg_wdata = '0;
    logic [7:0]     cfg_rdata;
    logic [NCH-1:0] tclk_i = '0, tx_pos_i = '0, tx_neg_i = '0, rlos_i = '0;
    logic [NCH-1:0] line_tx_pos_o, line_tx_neg_o;
    logic [NCH-1:0] rclk_i = '0, line_rx_pos_i = '0, line_rx_neg_i = '0;
    logic [NCH-1:0] rx_pos_o, rx_neg_o;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] lfsr = 32'h1357_9BDF;

    // Reference model state per channel (0 pass, 1 last mark pos, 2 last mark neg)
    logic m_tp [NCH];
    logic m_tn [NCH];
    logic m_rp [NCH];
    logic m_rn [NCH];
    int   m_st [NCH];

    always #2.5 clk = ~clk;

    liu_sysif #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tclk_i(tclk_i), .tx_pos_i(tx_pos_i),
        .tx_neg_i(tx_neg_i), .rlos_i(rlos_i), .line_tx_pos_o(line_tx_pos_o),
        .line_tx_neg_o(line_tx_neg_o), .rclk_i(rclk_i),
        .line_rx_pos_i(line_rx_pos_i), .line_rx_neg_i(line_rx_neg_i),
        .rx_pos_o(rx_pos_o), .rx_neg_o(rx_neg_o)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp,
                         input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic advance();
        for (int k = 0; k < 5; k++)
            lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
    endtask

    task automatic write_cfg(input logic [4:0] c);
        cfg_we    = 1'b1;
        cfg_wdata = {c, 3'b111};
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = 8'hFF;
        // R2: reserved bits written as ones read back as zero
        check("R2", cfg_rdata[1:0], 2'b00, "rdata[1:0]");
        check("R2", {1'b0, cfg_rdata[2]}, 2'b00, "rdata[2]");
        vectors++;
        if (cfg_rdata !== {c, 3'b000}) begin
            fails++;
            $display("FAIL R2 rdata actual=%h expected=%h", cfg_rdata, {c, 3'b000});
        end
    endtask

    // One clk cycle of stimulus: drive at a falling clk edge, compare at the next.
    task automatic step(input logic [4:0] c);
        logic sgl, ones, rxf, txr, pol;
        logic t_edge [NCH];
        logic r_edge [NCH];
        logic forced [NCH];
        sgl = c[4]; ones = c[3]; rxf = c[2]; txr = c[1]; pol = c[0];
        advance();
        for (int ch = 0; ch < NCH; ch++) begin
            logic [7:0] r;
            logic nt, nr;
            r  = lfsr[ch*8 +: 8];
            nt = tclk_i[ch] ^ r[0];
            nr = rclk_i[ch] ^ r[1];
            t_edge[ch] = txr ? (nt & ~tclk_i[ch]) : (~nt & tclk_i[ch]);
            r_edge[ch] = rxf ? (~nr & rclk_i[ch]) : (nr & ~rclk_i[ch]);
            tclk_i[ch]        = nt;
            rclk_i[ch]        = nr;
            tx_pos_i[ch]      = r[2];
            tx_neg_i[ch]      = r[3];
            line_rx_pos_i[ch] = r[4];
            line_rx_neg_i[ch] = r[5];
            if (r[6] & r[7]) rlos_i[ch] = ~rlos_i[ch];
            forced[ch] = ones & rlos_i[ch];
            if (t_edge[ch]) begin
                if (!forced[ch]) begin
                    m_st[ch] = 0;
                    m_tp[ch] = r[2] ^ pol;
                    m_tn[ch] = sgl ? 1'b0 : (r[3] ^ pol);
                end else if (m_st[ch] == 1 && !sgl) begin
                    m_st[ch] = 2; m_tp[ch] = 1'b0; m_tn[ch] = 1'b1;
                end else begin
                    m_st[ch] = 1; m_tp[ch] = 1'b1; m_tn[ch] = 1'b0;
                end
            end
            if (r_edge[ch]) begin
                m_rp[ch] = r[4] ^ pol;
                m_rn[ch] = r[5] ^ pol;
            end
        end
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            string ttag, rtag;
            if (!t_edge[ch])      ttag = "R10";
            else if (forced[ch])  ttag = pol ? "R9" : (sgl ? "R7" : "R8");
            else if (sgl)         ttag = "R6";
            else if (pol)         ttag = "R5";
            else                  ttag = "R3";
            if (sgl)              rtag = "R6";
            else if (pol)         rtag = "R5";
            else                  rtag = "R4";
            check(ttag, {line_tx_pos_o[ch], line_tx_neg_o[ch]}, {m_tp[ch], m_tn[ch]},
                  $sformatf("tx ch%0d cfg=%b", ch, c));
            check(rtag, {rx_pos_o[ch], rx_neg_o[ch]},
                  {m_rp[ch], sgl ? 1'b0 : m_rn[ch]},
                  $sformatf("rx ch%0d cfg=%b", ch, c));
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            m_tp[ch] = 0; m_tn[ch] = 0; m_rp[ch] = 0; m_rn[ch] = 0; m_st[ch] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", cfg_rdata[7:6], 2'b00, "rdata[7:6]");
        check("R1", cfg_rdata[5:4], 2'b00, "rdata[5:4]");
        for (int ch = 0; ch < NCH; ch++) begin
            check("R1", {line_tx_pos_o[ch], line_tx_neg_o[ch]}, 2'b00, "tx after reset");
            check("R1", {rx_pos_o[ch], rx_neg_o[ch]}, 2'b00, "rx after reset");
        end
        // Sweep every control setting; R3..R10 are checked by step()
        for (int c = 0; c < 32; c++) begin
            write_cfg(c[4:0]);
            for (int s = 0; s < 40; s++) step(c[4:0]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule